// File: doc/BRIEF.md
# Step Pulse Microstep Interpolator

This block sits between a step/direction command input and a motor phase sequencer. It accepts step pulses at a coarse microstep resolution and keeps a fine position counter with 256 counts per full step. With interpolation off, each active step edge moves the fine position by the whole coarse step at once. With interpolation on, the block spreads those fine counts evenly over time. It uses the length of the preceding step interval as the time base, so the motor moves smoothly instead of jumping once per input pulse.

A timeout watches the gaps between active edges. When no edge arrives within the configured limit, the block raises a standstill flag and a request to drop the motor to holding current. Both outputs clear on the next active edge. Because the first edge after standstill or after reset has no measured interval to work from, that edge moves the full coarse step at once.

Top module: `step_interp`

## Requirements
- R1: After reset the fine position is 0, and the strobe, standstill flag and hold request are all low.
- R2: With interpolation off, each active edge moves the fine position by 256 >> res_i in a single clock. The resolution code res_i runs from 0 (256 per edge) to 7 (2 per edge).
- R3: DIR is sampled with each active edge. A value of 1 increments the fine position and 0 decrements it. The 10-bit position wraps modulo 1024.
- R4: With interpolation on and a valid previous interval of T clocks, the edge leaves the position at the previous step's target. The block then issues one fine step every P = max(1, floor(T / (256 >> res_i))) clocks, stopping after 256 >> res_i steps.
- R5: The first active edge after reset, or after standstill, moves the full coarse step at once, even with interpolation on.
- R6: An active edge that arrives before the current step's fine steps are all issued snaps the position to that step's target. The unissued steps are dropped.
- R7: A change in step rate alters the fine step period only from the following interval. The period used after an edge comes from the interval that this edge ended.
- R8: With fast standstill off, the standstill flag rises 2^SLOW_EXP clocks after the last active edge.
- R9: With fast standstill on, the standstill flag rises 2^FAST_EXP clocks after the last active edge.
- R10: The hold request is high exactly while the standstill flag is high. Both clear on the next active edge.
- R11: With double-edge off, only rising STEP edges are active. With double-edge on, falling edges are active as well.
- R12: The strobe is high for one clock in each cycle in which the fine position changes, and never otherwise. No fine steps are issued while standstill persists.
- R13: A STEP edge affects the position on the third rising clock edge after it, because STEP and DIR pass through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Asynchronous step pulse input |
| dir_i | input | 1 | Asynchronous direction input, 1 = increment |
| intpol_en_i | input | 1 | Enables time interpolation of fine steps |
| dedge_en_i | input | 1 | Makes falling STEP edges active too |
| fast_stst_i | input | 1 | Selects the short standstill timeout |
| res_i | input | 3 | Input resolution code, coarse step = 256 >> res_i |
| pos_o | output | 10 | Fine microstep position, 256 per full step |
| ustep_o | output | 1 | One-clock pulse per fine position change |
| stst_o | output | 1 | Standstill flag |
| hold_o | output | 1 | Holding-current request |

## Verification
The bench drives an edge that lands on the same clock as the last scheduled fine step. A design that did not give the edge priority would lose or duplicate a count. It then shortens the step interval by half mid-stream and checks two things: the old period is still in force until the next edge, and the early edge snaps the position. A design that adopted the new rate at once, or kept the dropped steps pending, would show a different position at fixed clocks. The standstill threshold is probed a few clocks on either side for both timeout choices. The first edge after standstill is checked to jump a full coarse step; a design that interpolated from a saturated interval would creep instead.

// File: rtl/step_interp.sv
module step_interp #(
  parameter int POS_W    = 10,
  parameter int SLOW_EXP = 20,
  parameter int FAST_EXP = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic             intpol_en_i,
  input  logic             dedge_en_i,
  input  logic             fast_stst_i,
  input  logic [2:0]       res_i,
  output logic [POS_W-1:0] pos_o,
  output logic             ustep_o,
  output logic             stst_o,
  output logic             hold_o
);
  localparam int CNT_W = SLOW_EXP + 1;
  localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(1) << SLOW_EXP;
  localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(1) << FAST_EXP;

  logic [2:0] step_sync;
  logic [1:0] dir_sync;
  logic       act_edge, dir_s;

  logic [CNT_W-1:0] ivl_q, sub_cnt_q, sub_len_q;
  logic [POS_W-1:0] pos_q, target_q;
  logic [8:0]       remain_q;
  logic             cur_dir_q, stst_q, have_ref_q, ustep_q;

  logic [8:0]       n_steps;
  logic [3:0]       shift;
  logic [CNT_W-1:0] sub_raw, sub_len, limit;
  logic [POS_W-1:0] delta, target_next;
  logic             interp_go, timeout;

  assign dir_s    = dir_sync[1];
  assign act_edge = (step_sync[1] & ~step_sync[2]) |
                    (dedge_en_i & ~step_sync[1] & step_sync[2]);

  assign n_steps     = 9'd256 >> res_i;
  assign shift       = 4'd8 - {1'b0, res_i};
  assign sub_raw     = ivl_q >> shift;
  assign sub_len     = (sub_raw == '0) ? CNT_W'(1) : sub_raw;
  assign limit       = fast_stst_i ? LIM_FAST : LIM_SLOW;
  assign timeout     = ivl_q >= limit;
  assign delta       = POS_W'(n_steps);
  assign target_next = dir_s ? target_q + delta : target_q - delta;
  assign interp_go   = intpol_en_i & have_ref_q & ~stst_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      step_sync <= '0;
      dir_sync  <= '0;
    end else begin
      step_sync <= {step_sync[1:0], step_i};
      dir_sync  <= {dir_sync[0], dir_i};
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ivl_q      <= '0;
      sub_cnt_q  <= '0;
      sub_len_q  <= CNT_W'(1);
      pos_q      <= '0;
      target_q   <= '0;
      remain_q   <= '0;
      cur_dir_q  <= 1'b1;
      stst_q     <= 1'b0;
      have_ref_q <= 1'b0;
      ustep_q    <= 1'b0;
    end else begin
      ustep_q <= 1'b0;
      if (act_edge) begin
        ivl_q      <= CNT_W'(1);
        stst_q     <= 1'b0;
        have_ref_q <= 1'b1;
        target_q   <= target_next;
        cur_dir_q  <= dir_s;
        sub_cnt_q  <= '0;
        if (interp_go) begin
          sub_len_q <= sub_len;
          remain_q  <= n_steps;
          pos_q     <= target_q;
          ustep_q   <= (pos_q != target_q);
        end else begin
          remain_q  <= '0;
          pos_q     <= target_next;
          ustep_q   <= 1'b1;
        end
      end else begin
        if (ivl_q < LIM_SLOW) ivl_q <= ivl_q + CNT_W'(1);
        if (timeout) begin
          stst_q     <= 1'b1;
          have_ref_q <= 1'b0;
        end
        if (remain_q != '0) begin
          if (sub_cnt_q + CNT_W'(1) >= sub_len_q) begin
            sub_cnt_q <= '0;
            remain_q  <= remain_q - 9'd1;
            pos_q     <= cur_dir_q ? pos_q + POS_W'(1) : pos_q - POS_W'(1);
            ustep_q   <= 1'b1;
          end else begin
            sub_cnt_q <= sub_cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign pos_o   = pos_q;
  assign ustep_o = ustep_q;
  assign stst_o  = stst_q;
  assign hold_o  = stst_q;
endmodule

// File: rtl/step_interp_chk.sv
module step_interp_chk #(
  parameter int POS_W    = 10,
  parameter int SLOW_EXP = 20,
  parameter int FAST_EXP = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             act_edge,
  input logic             fast_stst_i,
  input logic [POS_W-1:0] pos_o,
  input logic             ustep_o,
  input logic             stst_o,
  input logic             hold_o
);
  localparam int CHK_W = SLOW_EXP + 2;
  localparam logic [CHK_W-1:0] C_SLOW = CHK_W'(1) << SLOW_EXP;
  localparam logic [CHK_W-1:0] C_FAST = CHK_W'(1) << FAST_EXP;
  localparam logic [CHK_W-1:0] C_SAT  = C_SLOW + CHK_W'(4);

  logic [CHK_W-1:0] idle_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)          idle_q <= '0;
    else if (act_edge)    idle_q <= CHK_W'(1);
    else if (idle_q < C_SAT) idle_q <= idle_q + CHK_W'(1);
  end

  AST_POS_CHANGE_STROBED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pos_o) |-> ustep_o); // R12
  AST_STROBE_MEANS_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ustep_o |-> !$stable(pos_o)); // R12
  AST_QUIET_IN_STANDSTILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stst_o && $past(stst_o)) |-> !ustep_o); // R12
  AST_STST_AFTER_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stst_o) |-> (idle_q >= ($past(fast_stst_i) ? C_FAST : C_SLOW))); // R8
  AST_HOLD_CLEARS_WITH_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> $past(act_edge)); // R10
endmodule

bind step_interp step_interp_chk #(
  .POS_W(POS_W), .SLOW_EXP(SLOW_EXP), .FAST_EXP(FAST_EXP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .act_edge(act_edge), .fast_stst_i(fast_stst_i),
  .pos_o(pos_o), .ustep_o(ustep_o), .stst_o(stst_o), .hold_o(hold_o)
);

// File: tb/step_interp_bench.sv
module step_interp_bench;
  logic clk = 1'b0;
  logic rst_n, step, dir, intpol, dedge, fast;
  logic [2:0] res;
  logic [9:0] pos;
  logic ustep, stst, hold;
  int n_chk = 0, n_bad = 0, scount = 0;

  always #5 clk = ~clk;

  step_interp #(.POS_W(10), .SLOW_EXP(10), .FAST_EXP(8)) u_step_interp (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .dir_i(dir),
    .intpol_en_i(intpol), .dedge_en_i(dedge), .fast_stst_i(fast), .res_i(res),
    .pos_o(pos), .ustep_o(ustep), .stst_o(stst), .hold_o(hold));

  always @(negedge clk) if (ustep) scount++;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step = 1'b0; dir = 1'b1; intpol = 1'b0; dedge = 1'b0;
    fast = 1'b0; res = 3'd4;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 pos", pos, 0);
    check("R1 ustep", ustep, 0);
    check("R1 stst", stst, 0);
    check("R1 hold", hold, 0);
  endtask

  task automatic t_nointerp();
    do_reset();
    scount = 0;
    step = 1'b1;
    tick(2); check("R13 not yet", pos, 0);
    tick(1); check("R2 res4 +16", pos, 16);
    step = 1'b0;
    tick(5); check("R11 fall ignored", pos, 16);
    check("R12 one strobe", scount, 1);
    res = 3'd7; step = 1'b1; tick(3); check("R2 res7 +2", pos, 18);
    step = 1'b0; tick(3);
    res = 3'd0; step = 1'b1; tick(3); check("R2 res0 +256", pos, 274);
    step = 1'b0; dir = 1'b0; tick(3);
    step = 1'b1; tick(3); check("R3 decrement", pos, 18);
    step = 1'b0; res = 3'd3; tick(3);
    step = 1'b1; tick(3); check("R3 wrap", pos, 1010);
    step = 1'b0; tick(3);
  endtask

  task automatic t_interp();
    do_reset();
    intpol = 1'b1; res = 3'd4; dir = 1'b1;
    step = 1'b1; tick(3); check("R5 first edge full", pos, 16);
    step = 1'b0; tick(317);
    step = 1'b1; tick(3); check("R4 no jump at edge", pos, 16);
    step = 1'b0; scount = 0;
    tick(100); check("R4 five steps at P=20", pos, 21);
    tick(216); check("R4 fifteen steps", pos, 31);
    check("R12 strobe count", scount, 15);
    tick(1);
    step = 1'b1; tick(3); check("R4 coincident edge", pos, 32);
    step = 1'b0; tick(156); check("R7 old period kept", pos, 39);
    tick(1);
    step = 1'b1; tick(3); check("R6 snap to target", pos, 48);
    check("R12 strobe on snap", ustep, 1);
    step = 1'b0;
    tick(50); check("R7 new period P=10", pos, 53);
    tick(947); check("R8 before timeout", stst, 0);
    tick(33); check("R8 after timeout", stst, 1);
    check("R10 hold set", hold, 1);
    check("R4 all steps issued", pos, 64);
    scount = 0; tick(50); check("R12 quiet in standstill", scount, 0);
    step = 1'b1; tick(3); check("R5 full after standstill", pos, 80);
    check("R10 stst cleared", stst, 0);
    check("R10 hold cleared", hold, 0);
    fast = 1'b1; step = 1'b0;
    tick(250); check("R9 before fast timeout", stst, 0);
    tick(10); check("R9 after fast timeout", stst, 1);
  endtask

  task automatic t_dedge();
    do_reset();
    dedge = 1'b1; res = 3'd2;
    step = 1'b1; tick(3); check("R11 rise +64", pos, 64);
    step = 1'b0; tick(3); check("R11 fall +64", pos, 128);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_nointerp();
    t_interp();
    t_dedge();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule